// File: doc/BRIEF.md
# Multi-Mode External Interrupt Front End

This block turns eight active-low external interrupt request pins and one active-low non-maskable pin into a single registered interrupt request for a processor core. Every pin is first passed through a synchronizer. A mode input decides how the eight request pins are read. In per-pin mode each pin is a source of its own. In vectored mode the eight pins together carry one 8-bit vector. In split mode the top three pins are sources of their own and the lower five pins carry the upper part of a vector.

A per-pin source can be set to react to a low level or to a falling edge. A falling edge sets a pending bit, and that bit stays set until the core acknowledges the source. The non-maskable pin always reacts to a falling edge and always wins over every other source. The winning request is captured in an output register and held there until the core sends a one-cycle acknowledge. After that the next winner is loaded.

Top module: `xirq_front`

## Requirements
- R1: While reset is asserted, and on the cycle after it, `req_valid_o` and `req_nmi_o` are 0.
- R2: In per-pin mode (mode 0, and also mode 3) with `edge_sel_i[k]`=0, a low pin k gives a request with vector k (zero-extended) and the NMI flag at 0. While the pin stays low, the request comes back after each acknowledge.
- R3: With `edge_sel_i[k]`=1, a falling edge on pin k gives a request with vector k even if the pin has gone high again. After that request is acknowledged, a pin that stays low or high gives no new request.
- R4: Among the per-pin sources that are requesting at the same time, the one with the highest pin index is reported first. The others follow, one after each acknowledge.
- R5: In vectored mode (mode 1) the vector is the bitwise inverse of the pins and the request is level sensitive. `edge_sel_i` has no effect. An all-high pin pattern (vector 0) means no request.
- R6: In split mode (mode 2), pins 7..5 act as per-pin sources with vectors 7..5. Pins 4..0 give the vector {~pins[4:0], 3'b010}. This vectored request is raised only while pins 4..0 are not all high.
- R7: In split mode, a per-pin source that is requesting wins over the vectored request.
- R8: A falling edge on `nmi_n_i` gives a request with `req_nmi_o`=1 and vector 0. It wins over every other source. After it is acknowledged, a pin that stays low does not raise it again.
- R9: While `req_valid_o` is 1 and `ack_i` is 0, the vector and the NMI flag do not change. When `ack_i` is 1 at a clock edge, `req_valid_o` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | 0 per-pin, 1 vectored, 2 split, 3 per-pin |
| edge_sel_i | input | 8 | Per pin: 1 falling edge, 0 low level |
| irq_n_i | input | 8 | Active-low interrupt request pins |
| nmi_n_i | input | 1 | Active-low non-maskable request, falling edge |
| ack_i | input | 1 | One-cycle acknowledge of the held request |
| req_valid_o | output | 1 | A request is held |
| req_vec_o | output | 8 | Vector of the held request |
| req_nmi_o | output | 1 | The held request is the non-maskable one |

## Verification
The bench fires an edge-mode source and the non-maskable pin on the same cycle. A design that ranked the NMI too low, or that lost the losing edge, would show the wrong vector first or would drop the second request. It checks that an edge source whose pin stays low does not fire again, which catches a pending bit that is set from the level instead of from the edge. It also checks that a level source does fire again. Random pin patterns in the vectored and split modes test the inverted vector and the fixed 3'b010 field. They also test that an all-high pattern counts as no request, so a swapped field or a missing inversion would give a wrong vector.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int VEC_W   = 8;
  localparam int DED_MIX = 3;
  localparam logic [DED_MIX-1:0] MIX_LOW = 3'b010;

  typedef enum logic [1:0] {
    MODE_DED = 2'd0,
    MODE_VEC = 2'd1,
    MODE_MIX = 2'd2,
    MODE_RSV = 2'd3
  } xirq_mode_e;

  typedef struct packed {
    logic             valid;
    logic             nmi;
    logic             ded;
    logic [VEC_W-1:0] vec;
  } xirq_pick_t;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= '1;
      else if (g == 0) chain[g] <= d;
      else chain[g] <= chain[(g == 0) ? 0 : g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_n,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] active,
  input  logic [W-1:0] clr,
  output logic [W-1:0] req
);
  logic [W-1:0] prev_n;
  logic [W-1:0] pend;
  logic [W-1:0] fall;

  assign fall = prev_n & ~lvl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_n <= '1;
      pend   <= '0;
    end else begin
      prev_n <= lvl_n;
      pend   <= ((pend & ~clr) | fall) & active & edge_sel;
    end
  end

  assign req = active & ((edge_sel & pend) | (~edge_sel & ~lvl_n));
endmodule

// File: rtl/xirq_arbiter.sv
module xirq_arbiter
  import xirq_pkg::*;
(
  input  xirq_mode_e       mode,
  input  logic [VEC_W-1:0] pins_n,
  input  logic [VEC_W-1:0] ded_req,
  input  logic             nmi_req,
  output xirq_pick_t       pick
);
  localparam int HI_W  = VEC_W - DED_MIX;
  localparam int IDX_W = $clog2(VEC_W);

  logic             vec_req;
  logic [VEC_W-1:0] vec_val;
  logic             ded_any;
  logic [IDX_W-1:0] ded_idx;

  always_comb begin
    vec_req = 1'b0;
    vec_val = '0;
    case (mode)
      MODE_VEC: begin
        vec_val = ~pins_n;
        vec_req = |vec_val;
      end
      MODE_MIX: begin
        vec_val = {~pins_n[HI_W-1:0], MIX_LOW};
        vec_req = |(~pins_n[HI_W-1:0]);
      end
      default: ;
    endcase
  end

  always_comb begin
    ded_any = 1'b0;
    ded_idx = '0;
    for (int i = 0; i < VEC_W; i++) begin
      if (ded_req[i]) begin
        ded_any = 1'b1;
        ded_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    pick = '0;
    if (nmi_req) begin
      pick.valid = 1'b1;
      pick.nmi   = 1'b1;
    end else if (ded_any) begin
      pick.valid = 1'b1;
      pick.ded   = 1'b1;
      pick.vec   = VEC_W'(ded_idx);
    end else if (vec_req) begin
      pick.valid = 1'b1;
      pick.vec   = vec_val;
    end
  end
endmodule

// File: rtl/xirq_front.sv
module xirq_front
  import xirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [VEC_W-1:0] edge_sel_i,
  input  logic [VEC_W-1:0] irq_n_i,
  input  logic             nmi_n_i,
  input  logic             ack_i,
  output logic             req_valid_o,
  output logic [VEC_W-1:0] req_vec_o,
  output logic             req_nmi_o
);
  localparam int IDX_W = $clog2(VEC_W);

  xirq_mode_e       mode;
  logic [VEC_W:0]   sync_all;
  logic [VEC_W-1:0] pins_s;
  logic             nmi_s;
  logic [VEC_W-1:0] ded_mask;
  logic [VEC_W-1:0] ded_req;
  logic [VEC_W-1:0] ded_clr;
  logic [0:0]       nmi_req;
  logic [0:0]       nmi_clr;
  xirq_pick_t       pick;
  logic             valid_q, nmi_q, ded_q;
  logic [VEC_W-1:0] vec_q;
  logic             take_ack;

  assign mode = xirq_mode_e'(mode_i);

  xirq_sync #(.W(VEC_W+1), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d ({nmi_n_i, irq_n_i}), .q (sync_all)
  );
  assign pins_s = sync_all[VEC_W-1:0];
  assign nmi_s  = sync_all[VEC_W];

  always_comb begin
    case (mode)
      MODE_VEC: ded_mask = '0;
      MODE_MIX: ded_mask = {{DED_MIX{1'b1}}, {(VEC_W-DED_MIX){1'b0}}};
      default:  ded_mask = '1;
    endcase
  end

  assign take_ack = valid_q && ack_i;
  assign ded_clr  = (take_ack && ded_q) ? (VEC_W'(1) << vec_q[IDX_W-1:0]) : '0;
  assign nmi_clr  = take_ack && nmi_q;

  xirq_detect #(.W(VEC_W)) u_ded (
    .clk (clk), .rst (rst), .lvl_n (pins_s), .edge_sel (edge_sel_i),
    .active (ded_mask), .clr (ded_clr), .req (ded_req)
  );

  xirq_detect #(.W(1)) u_nmi (
    .clk (clk), .rst (rst), .lvl_n (nmi_s), .edge_sel (1'b1),
    .active (1'b1), .clr (nmi_clr), .req (nmi_req)
  );

  xirq_arbiter u_arb (
    .mode (mode), .pins_n (pins_s), .ded_req (ded_req),
    .nmi_req (nmi_req[0]), .pick (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      nmi_q   <= 1'b0;
      ded_q   <= 1'b0;
      vec_q   <= '0;
    end else if (take_ack) begin
      valid_q <= 1'b0;
      nmi_q   <= 1'b0;
      ded_q   <= 1'b0;
    end else if (!valid_q && pick.valid) begin
      valid_q <= 1'b1;
      nmi_q   <= pick.nmi;
      ded_q   <= pick.ded;
      vec_q   <= pick.vec;
    end
  end

  assign req_valid_o = valid_q;
  assign req_vec_o   = vec_q;
  assign req_nmi_o   = nmi_q;
endmodule

// File: rtl/xirq_front_chk.sv
module xirq_front_chk
  import xirq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_i,
  input logic             ack_i,
  input logic             req_valid_o,
  input logic [VEC_W-1:0] req_vec_o,
  input logic             req_nmi_o
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!req_valid_o && !req_nmi_o));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !ack_i) |=> (req_valid_o && $stable(req_vec_o) && $stable(req_nmi_o)));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && ack_i) |=> !req_valid_o);

  a_r8_nmi_shape: assert property (@(posedge clk) disable iff (rst)
    req_nmi_o |-> (req_valid_o && req_vec_o == '0));

  a_r5_vec_nonzero: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_nmi_o && mode_i == MODE_VEC) |-> (req_vec_o != '0));

  a_r6_low_field: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_nmi_o && mode_i == MODE_MIX && req_vec_o >= VEC_W)
      |-> (req_vec_o[DED_MIX-1:0] == MIX_LOW));
endmodule

bind xirq_front xirq_front_chk u_chk (
  .clk (clk), .rst (rst), .mode_i (mode_i), .ack_i (ack_i),
  .req_valid_o (req_valid_o), .req_vec_o (req_vec_o), .req_nmi_o (req_nmi_o)
);

// File: tb/xirq_front_test.sv
module xirq_front_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_i = 2'd0;
  logic [7:0] edge_sel_i = 8'h00;
  logic [7:0] irq_n_i = 8'hFF;
  logic       nmi_n_i = 1'b1;
  logic       ack_i = 1'b0;
  logic       req_valid_o;
  logic [7:0] req_vec_o;
  logic       req_nmi_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  xirq_front uut (
    .clk (clk), .rst (rst), .mode_i (mode_i), .edge_sel_i (edge_sel_i),
    .irq_n_i (irq_n_i), .nmi_n_i (nmi_n_i), .ack_i (ack_i),
    .req_valid_o (req_valid_o), .req_vec_o (req_vec_o), .req_nmi_o (req_nmi_o)
  );

  // packed as {valid, nmi, vec}
  function automatic logic [9:0] exp_ded(input logic [7:0] p);
    logic [9:0] r = 10'd0;
    for (int i = 0; i < 8; i++) if (!p[i]) r = {2'b10, 8'(i)};
    return r;
  endfunction

  function automatic logic [9:0] exp_vec(input logic [7:0] p);
    return (p == 8'hFF) ? 10'd0 : {2'b10, ~p};
  endfunction

  function automatic logic [9:0] exp_mix(input logic [7:0] p);
    logic [9:0] r = 10'd0;
    if (p[4:0] != 5'h1F) r = {2'b10, ~p[4:0], 3'b010};
    for (int i = 5; i < 8; i++) if (!p[i]) r = {2'b10, 8'(i)};
    return r;
  endfunction

  task automatic chk(input string req, input logic [9:0] exp);
    logic [9:0] got;
    got = {req_valid_o, req_nmi_o, req_vec_o};
    if (!exp[9]) got[7:0] = 8'h00;
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got valid=%b nmi=%b vec=%h, expected valid=%b nmi=%b vec=%h",
               req, got[9], got[8], got[7:0], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic ack();
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic drain();
    irq_n_i = 8'hFF;
    nmi_n_i = 1'b1;
    settle();
    for (int k = 0; k < 10 && req_valid_o; k++) begin
      ack();
      settle();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] p;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 in reset", 10'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 10'd0);

    // R2 random level patterns, per-pin mode (0 and 3)
    edge_sel_i = 8'h00;
    for (int it = 0; it < 40; it++) begin
      mode_i = (it % 2 == 0) ? 2'd0 : 2'd3;
      p = 8'($urandom);
      irq_n_i = p;
      settle();
      chk("R2 level pick", exp_ded(p));
      if (req_valid_o) begin
        ack();
        chk("R9 ack clears", 10'd0);
        settle();
        chk("R2 level repeats", exp_ded(p));
      end
      drain();
    end

    // R5 random vectored patterns, edge_sel ignored
    mode_i = 2'd1;
    for (int it = 0; it < 40; it++) begin
      edge_sel_i = 8'($urandom);
      p = (it == 0) ? 8'hFF : (it == 1) ? 8'h00 : 8'($urandom);
      irq_n_i = p;
      settle();
      chk("R5 vector value", exp_vec(p));
      if (req_valid_o) begin
        irq_n_i = 8'($urandom);
        repeat (3) @(negedge clk);
        chk("R9 held while pins move", exp_vec(p));
      end
      drain();
    end

    // R6 R7 random split patterns
    mode_i = 2'd2;
    edge_sel_i = 8'h00;
    for (int it = 0; it < 40; it++) begin
      p = (it == 0) ? 8'hFF : (it == 1) ? 8'hE0 : 8'($urandom);
      irq_n_i = p;
      settle();
      chk("R6 R7 split pick", exp_mix(p));
      drain();
    end

    // R7 directed: pin 5 beats vectored field, then vectored shows
    irq_n_i = 8'hC0;
    settle();
    chk("R7 per-pin wins", {2'b10, 8'd5});
    irq_n_i = 8'hE0;
    settle();
    ack();
    settle();
    chk("R6 vector after ack", {2'b10, 8'hFA});
    drain();

    // R3 edge source, pulse then released
    mode_i = 2'd0;
    edge_sel_i = 8'h08;
    irq_n_i = 8'hF7;
    settle();
    irq_n_i = 8'hFF;
    settle();
    chk("R3 edge latched", {2'b10, 8'd3});
    ack();
    settle();
    chk("R3 no repeat", 10'd0);
    // R3 edge source held low after ack
    irq_n_i = 8'hF7;
    settle();
    chk("R3 edge fires", {2'b10, 8'd3});
    ack();
    settle();
    chk("R3 held low no repeat", 10'd0);
    drain();

    // R4 two edges on the same cycle
    edge_sel_i = 8'h44;
    irq_n_i = 8'hBB;
    settle();
    irq_n_i = 8'hFF;
    chk("R4 high index first", {2'b10, 8'd6});
    ack();
    settle();
    chk("R4 lower index next", {2'b10, 8'd2});
    ack();
    settle();
    chk("R4 none left", 10'd0);

    // R8 NMI with edge pin 7 on the same cycle
    edge_sel_i = 8'h80;
    nmi_n_i = 1'b0;
    irq_n_i = 8'h7F;
    settle();
    chk("R8 nmi wins", {2'b11, 8'h00});
    ack();
    settle();
    chk("R8 pin after nmi", {2'b10, 8'd7});
    ack();
    settle();
    chk("R8 nmi held low no repeat", 10'd0);
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule